// File: doc/BRIEF.md
# Trace Cache with Prefix Supply

The block caches dynamic instruction sequences (traces) so that a front end can fetch across several basic blocks in a single lookup. Each line holds up to 8 instructions that span up to 3 basic blocks. A line is keyed by the start address of its trace and by the directions of its first two internal branches. A lookup presents a fetch address and the predicted directions for the next two branches. The block returns the stored instructions, how many of them are valid, and the address at which fetching should resume.

When the start address matches but only the leading predictions agree with the stored directions, the block still hits. It supplies only the trace prefix that ends at the first disagreeing branch, and it redirects the next fetch according to the predicted direction of that branch. When the lookup misses, the fetch unit takes the instruction cache path.

Traces are built by a fill buffer from the retired instruction stream, which arrives in program order. The buffer closes a trace at the eighth instruction or at the third branch, whichever comes first. It then writes the trace into a direct-mapped array of 16 lines, indexed by the low bits of the start address. Fetch and instruction addresses are word addresses, so the sequential successor of address A is A+1.

Top module: `trace_cache`

## Requirements
- R1: After reset every line is invalid, so every lookup misses.
- R2: A trace closes after its eighth retired instruction. Its line is indexed by start address bits [3:0] and tagged with bits [15:4]. A full hit returns all 8 instructions, slot 0 first, with next address = last pc + 1 when the last instruction is not a taken branch.
- R3: A trace closes at its third retired branch, which is included as the last instruction. Flags 0 and 1 record the taken outcome (1 = taken) of the first and second branch, and the next address follows the third branch's recorded outcome.
- R4: A lookup hits only when the start address of the stored trace equals the fetch address. Another address that maps to the same index misses.
- R5: On a hit where every used flag equals its prediction, lu_partial_o is 0, the count equals the trace length and the next address is the stored successor.
- R6: Prediction bit 0 belongs to the first branch and bit 1 to the second. If the first branch disagrees, the count is (first branch slot + 1), lu_partial_o is 1, and the next address is that branch's target if bit 0 is 1, or else its pc + 1.
- R7: If the first branch agrees and the second disagrees, the count is (second branch slot + 1), and the next address is chosen by bit 1 in the same way.
- R8: A prediction bit for a branch that the trace does not contain has no effect on the output.
- R9: Instruction slots at or beyond the valid count read as zero.
- R10: A new trace with the same index replaces the old line.
- R11: A lookup in the same cycle as a write to its line returns the line's previous contents.
- R12: A miss returns hit 0, count 0, next address 0 and all instruction slots zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lu_addr_i | input | 16 | Fetch address for the lookup |
| lu_pred_i | input | 2 | Predicted directions, bit 0 for the first branch |
| lu_hit_o | output | 1 | Start address matched a valid line |
| lu_partial_o | output | 1 | Only a prefix is supplied |
| lu_count_o | output | 4 | Number of valid instruction slots |
| lu_instr_o | output | 256 | Instruction slots, slot 0 in bits [31:0] |
| lu_next_o | output | 16 | Address at which fetching resumes |
| rt_valid_i | input | 1 | A retired instruction is presented |
| rt_pc_i | input | 16 | Address of the retired instruction |
| rt_instr_i | input | 32 | Retired instruction word |
| rt_branch_i | input | 1 | The retired instruction is a conditional branch |
| rt_taken_i | input | 1 | The branch was taken |
| rt_target_i | input | 16 | Target of the branch |

## Verification
A corrupt flag or branch slot in a stored line shows up in the first lookup of that line. The count or next address is then wrong in the very cycle the lookup is presented, because the read path is combinational. A fill buffer that miscounts closes a trace early or late. That appears as a wrong length, or as a miss, on the first lookup after the expected closing retirement. A write that lands in the wrong cycle or line is caught by the same-cycle lookup that must still see the old line, and by the following cycle, which must see the new one.

// File: rtl/tc_pkg.sv
package tc_pkg;
  parameter int AW      = 16;
  parameter int IW      = 32;
  parameter int N_INS   = 8;
  parameter int M_BLK   = 3;
  parameter int N_LINES = 16;

  localparam int NF    = M_BLK - 1;
  localparam int IDX_W = $clog2(N_LINES);
  localparam int TAG_W = AW - IDX_W;
  localparam int POS_W = $clog2(N_INS);
  localparam int LEN_W = $clog2(N_INS + 1);
  localparam int BC_W  = $clog2(M_BLK + 1);

  typedef struct packed {
    logic                      valid;
    logic [TAG_W-1:0]          tag;
    logic [NF-1:0]             flags;
    logic [BC_W-1:0]           br_cnt;
    logic [LEN_W-1:0]          len;
    logic [NF-1:0][POS_W-1:0]  pos;
    logic [NF-1:0][AW-1:0]     tgt;
    logic [NF-1:0][AW-1:0]     fall;
    logic [AW-1:0]             next;
    logic [N_INS-1:0][IW-1:0]  instr;
  } line_t;
endpackage

// File: rtl/tc_fill_buf.sv
module tc_fill_buf
  import tc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rt_valid_i,
  input  logic [AW-1:0]    rt_pc_i,
  input  logic [IW-1:0]    rt_instr_i,
  input  logic             rt_branch_i,
  input  logic             rt_taken_i,
  input  logic [AW-1:0]    rt_target_i,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output line_t            wr_line_o
);
  logic [LEN_W-1:0] cnt_q;
  line_t            buf_q, line_n;
  logic [AW-1:0]    start_q, start_n;
  logic             close;

  always_comb begin
    line_n  = buf_q;
    start_n = (cnt_q == '0) ? rt_pc_i : start_q;
    line_n.instr[cnt_q[POS_W-1:0]] = rt_instr_i;
    for (int k = 0; k < NF; k++) begin
      if (rt_branch_i && buf_q.br_cnt == BC_W'(k)) begin
        line_n.pos[k]   = cnt_q[POS_W-1:0];
        line_n.flags[k] = rt_taken_i;
        line_n.tgt[k]   = rt_target_i;
        line_n.fall[k]  = rt_pc_i + AW'(1);
      end
    end
    line_n.br_cnt = buf_q.br_cnt + BC_W'(rt_branch_i);
    line_n.len    = cnt_q + LEN_W'(1);
    line_n.next   = (rt_branch_i && rt_taken_i) ? rt_target_i : rt_pc_i + AW'(1);
    line_n.valid  = 1'b1;
    line_n.tag    = start_n[AW-1:IDX_W];
    close = rt_valid_i &&
            (cnt_q == LEN_W'(N_INS - 1) || (rt_branch_i && buf_q.br_cnt == BC_W'(M_BLK - 1)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      buf_q   <= '0;
      start_q <= '0;
    end else if (rt_valid_i) begin
      if (close) begin
        cnt_q <= '0;
        buf_q <= '0;
      end else begin
        cnt_q   <= cnt_q + LEN_W'(1);
        buf_q   <= line_n;
        start_q <= start_n;
      end
    end
  end

  assign wr_en_o   = close;
  assign wr_idx_o  = start_n[IDX_W-1:0];
  assign wr_line_o = line_n;

  assert_fill_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < LEN_W'(N_INS));
  assert_fill_br_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_q.br_cnt < BC_W'(M_BLK));
  assert_close_reset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> cnt_q == '0);
endmodule

// File: rtl/tc_store.sv
module tc_store
  import tc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  line_t            wr_line_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output line_t            rd_line_o
);
  line_t mem_q [N_LINES];

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 mem_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(g))   mem_q[g] <= wr_line_i;
    end

    assert_line_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_idx_i == IDX_W'(g)) |=> mem_q[g] == $past(wr_line_i));
  end

  // read before write: same-cycle lookup sees old line
  assign rd_line_o = mem_q[rd_idx_i];
endmodule

// File: rtl/tc_match.sv
module tc_match
  import tc_pkg::*;
(
  input  line_t                 line_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [NF-1:0]         pred_i,
  output logic                  hit_o,
  output logic                  partial_o,
  output logic [LEN_W-1:0]      count_o,
  output logic [AW-1:0]         next_o,
  output logic [N_INS*IW-1:0]   instr_o
);
  logic [BC_W-1:0] used;
  logic            found;

  always_comb begin
    hit_o     = line_i.valid && (line_i.tag == addr_i[AW-1:IDX_W]);
    used      = (line_i.br_cnt > BC_W'(NF)) ? BC_W'(NF) : line_i.br_cnt;
    partial_o = 1'b0;
    count_o   = '0;
    next_o    = '0;
    found     = 1'b0;
    if (hit_o) begin
      count_o = line_i.len;
      next_o  = line_i.next;
      for (int k = 0; k < NF; k++) begin
        if (!found && BC_W'(k) < used && line_i.flags[k] != pred_i[k]) begin
          found     = 1'b1;
          partial_o = 1'b1;
          count_o   = LEN_W'(line_i.pos[k]) + LEN_W'(1);
          next_o    = pred_i[k] ? line_i.tgt[k] : line_i.fall[k];
        end
      end
    end
    for (int s = 0; s < N_INS; s++)
      instr_o[s*IW +: IW] = (LEN_W'(s) < count_o) ? line_i.instr[s] : '0;
  end
endmodule

// File: rtl/trace_cache.sv
module trace_cache
  import tc_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [AW-1:0]        lu_addr_i,
  input  logic [NF-1:0]        lu_pred_i,
  output logic                 lu_hit_o,
  output logic                 lu_partial_o,
  output logic [LEN_W-1:0]     lu_count_o,
  output logic [N_INS*IW-1:0]  lu_instr_o,
  output logic [AW-1:0]        lu_next_o,
  input  logic                 rt_valid_i,
  input  logic [AW-1:0]        rt_pc_i,
  input  logic [IW-1:0]        rt_instr_i,
  input  logic                 rt_branch_i,
  input  logic                 rt_taken_i,
  input  logic [AW-1:0]        rt_target_i
);
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  line_t            wr_line, rd_line;

  tc_fill_buf u_fill (
    .clk_i, .rst_ni, .rt_valid_i, .rt_pc_i, .rt_instr_i, .rt_branch_i,
    .rt_taken_i, .rt_target_i,
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_line_o(wr_line)
  );

  tc_store u_store (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_line_i(wr_line),
    .rd_idx_i(lu_addr_i[IDX_W-1:0]), .rd_line_o(rd_line)
  );

  tc_match u_match (
    .line_i(rd_line), .addr_i(lu_addr_i), .pred_i(lu_pred_i),
    .hit_o(lu_hit_o), .partial_o(lu_partial_o), .count_o(lu_count_o),
    .next_o(lu_next_o), .instr_o(lu_instr_o)
  );

  assert_reset_miss_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !lu_hit_o);
  assert_miss_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lu_hit_o |-> (lu_count_o == '0 && lu_next_o == '0 && lu_instr_o == '0));
  assert_hit_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lu_hit_o |-> (lu_count_o != '0 && lu_count_o <= LEN_W'(N_INS)));
  assert_prefix_short_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lu_partial_o |-> (lu_hit_o && lu_count_o <= rd_line.len));
  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(lu_addr_i) && $stable(lu_pred_i) && !$past(wr_en))
      |-> ($stable(lu_count_o) && $stable(lu_next_o) && $stable(lu_hit_o)));
endmodule

// File: tb/trace_cache_bench.sv
module trace_cache_bench;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [15:0]  lu_addr = '0;
  logic [1:0]   lu_pred = '0;
  logic         lu_hit, lu_partial;
  logic [3:0]   lu_count;
  logic [255:0] lu_instr;
  logic [15:0]  lu_next;
  logic         rt_valid = 1'b0, rt_branch = 1'b0, rt_taken = 1'b0;
  logic [15:0]  rt_pc = '0, rt_target = '0;
  logic [31:0]  rt_instr = '0;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  string req = "R1";

  always #10 clk = ~clk;

  trace_cache u_trace_cache (
    .clk_i(clk), .rst_ni(rst_ni), .lu_addr_i(lu_addr), .lu_pred_i(lu_pred),
    .lu_hit_o(lu_hit), .lu_partial_o(lu_partial), .lu_count_o(lu_count),
    .lu_instr_o(lu_instr), .lu_next_o(lu_next),
    .rt_valid_i(rt_valid), .rt_pc_i(rt_pc), .rt_instr_i(rt_instr),
    .rt_branch_i(rt_branch), .rt_taken_i(rt_taken), .rt_target_i(rt_target)
  );

  // behavioural model
  bit          m_valid [16];
  logic [15:0] m_start [16];
  int          m_len [16], m_br [16];
  int          m_pos [16][2];
  bit          m_flag [16][2];
  logic [15:0] m_tgt [16][2], m_fall [16][2], m_next [16];
  logic [31:0] m_ins [16][8];
  logic [15:0] q_pc[$], q_tg[$];
  logic [31:0] q_ins[$];
  bit          q_br[$], q_tk[$];

  task automatic model_push();
    int nbr = 0;
    q_pc.push_back(rt_pc); q_ins.push_back(rt_instr); q_br.push_back(rt_branch);
    q_tk.push_back(rt_taken); q_tg.push_back(rt_target);
    foreach (q_br[i]) if (q_br[i]) nbr++;
    if (q_pc.size() == 8 || nbr == 3) begin
      int ix = int'(q_pc[0][3:0]);
      int b = 0;
      int last = q_pc.size() - 1;
      m_valid[ix] = 1; m_start[ix] = q_pc[0]; m_len[ix] = q_pc.size();
      for (int s = 0; s < 8; s++) m_ins[ix][s] = (s < q_pc.size()) ? q_ins[s] : 32'h0;
      for (int i = 0; i < q_pc.size(); i++) begin
        if (q_br[i]) begin
          if (b < 2) begin
            m_pos[ix][b] = i; m_flag[ix][b] = q_tk[i];
            m_tgt[ix][b] = q_tg[i]; m_fall[ix][b] = q_pc[i] + 16'd1;
          end
          b++;
        end
      end
      m_br[ix] = b;
      m_next[ix] = (q_br[last] && q_tk[last]) ? q_tg[last] : q_pc[last] + 16'd1;
      q_pc.delete(); q_ins.delete(); q_br.delete(); q_tk.delete(); q_tg.delete();
    end
  endtask

  task automatic chk(bit ok, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h exp %h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    int ix = int'(lu_addr[3:0]);
    bit e_hit, e_part = 0;
    int e_cnt = 0;
    logic [15:0] e_next = '0;
    e_hit = m_valid[ix] && m_start[ix] == lu_addr;
    if (e_hit) begin
      int nf = (m_br[ix] < 2) ? m_br[ix] : 2;
      e_cnt = m_len[ix]; e_next = m_next[ix];
      for (int k = 0; k < nf; k++) begin
        if (m_flag[ix][k] != lu_pred[k]) begin
          e_cnt = m_pos[ix][k] + 1;
          e_next = lu_pred[k] ? m_tgt[ix][k] : m_fall[ix][k];
          e_part = 1;
          break;
        end
      end
    end
    chk(lu_hit == e_hit, "hit", 32'(lu_hit), 32'(e_hit));
    chk(lu_partial == e_part, "partial", 32'(lu_partial), 32'(e_part));
    chk(int'(lu_count) == e_cnt, "count", 32'(lu_count), 32'(e_cnt));
    chk(lu_next == e_next, "next", 32'(lu_next), 32'(e_next));
    for (int s = 0; s < 8; s++) begin
      logic [31:0] e_i = (s < e_cnt) ? m_ins[ix][s] : 32'h0;
      chk(lu_instr[s*32 +: 32] == e_i, (s < e_cnt) ? "instr slot" : "R9 zero slot",
          lu_instr[s*32 +: 32], e_i);
    end
  endtask

  task automatic cyc();
    #8;
    compare();
    @(posedge clk);
    if (rst_ni && rt_valid) model_push();
    @(negedge clk);
  endtask

  function automatic logic [31:0] mk(logic [15:0] pc);
    return {pc ^ 16'h5A5A, pc};
  endfunction

  task automatic retire(logic [15:0] pc, bit br, bit tk, logic [15:0] tg);
    rt_valid = 1; rt_pc = pc; rt_instr = mk(pc); rt_branch = br; rt_taken = tk; rt_target = tg;
    cyc();
    rt_valid = 0; rt_branch = 0; rt_taken = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    foreach (m_valid[i]) m_valid[i] = 0;
    lu_addr = 16'h0010;
    repeat (2) @(negedge clk);
    req = "R1"; cyc();
    rst_ni = 1; cyc(); cyc();

    // R2: eight straight-line instructions
    req = "R2"; lu_addr = 16'h0100;
    for (int i = 0; i < 8; i++) retire(16'h0100 + 16'(i), 0, 0, 0);
    cyc();
    req = "R8"; lu_pred = 2'b11; cyc();

    // R3: closes at third branch; flags {0,1}
    req = "R3"; lu_addr = 16'h0123; lu_pred = 2'b01;
    retire(16'h0123, 0, 0, 0);
    retire(16'h0124, 1, 1, 16'h0200);
    retire(16'h0200, 1, 0, 16'h0280);
    retire(16'h0201, 0, 0, 0);
    retire(16'h0202, 1, 1, 16'h0300);
    cyc();
    req = "R5"; cyc();
    req = "R6"; lu_pred = 2'b00; cyc();
    lu_pred = 2'b10; cyc();
    req = "R7"; lu_pred = 2'b11; cyc();

    // R4: same index, other tag
    req = "R4"; lu_addr = 16'h0203; cyc();
    lu_addr = 16'h0113; cyc();

    // R11 then R10: overwrite index 3 while looking it up
    req = "R11"; lu_addr = 16'h0123; lu_pred = 2'b01;
    for (int i = 0; i < 8; i++) retire(16'h0223 + 16'(i), 0, 0, 0);
    req = "R10"; cyc();
    lu_addr = 16'h0223; cyc();

    // R8: single branch, second prediction bit unused
    req = "R8"; lu_addr = 16'h0405; lu_pred = 2'b00;
    retire(16'h0405, 1, 0, 16'h0500);
    for (int i = 1; i < 8; i++) retire(16'h0405 + 16'(i), 0, 0, 0);
    cyc();
    lu_pred = 2'b10; cyc();
    req = "R6"; lu_pred = 2'b01; cyc();

    // R12: plain miss
    req = "R12"; lu_addr = 16'h7777; cyc();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule